// File: doc/BRIEF.md
# Staged Watchdog Controller

This block is a watchdog timer for a system on chip. It holds a small set of down-counting timers that run on a 1 MHz tick enable. Each timer has a period register, with an enable bit and a bit that chooses between periodic and one-shot operation, and an expiry flag that software clears by writing to it. The watchdog itself follows one timer, chosen in its configuration register. Once software has started it, each expiry of that timer moves the watchdog one stage further: first a normal interrupt, then a fast interrupt, and finally a reset request.

Software keeps the system alive by issuing a restart command before the reset stage is reached. The command returns the watchdog to idle and reloads the count of the selected timer. A second mode has only two stages: the first expiry raises the interrupt and a second expiry, arriving before a restart, goes straight to reset. Turning the watchdog off takes two writes. A key must first go to the unlock register, and the disable command that follows is the only one that is accepted. The bus is a plain single-cycle register port with registered read data.

Top module: `stagewd_top`

## Requirements
- R1: After a synchronous reset every output is low. Status, configuration, every timer period and every timer control register read 0.
- R2: A timer whose period register (address 0x10 + 8*i) has bit 31 set and a count P > 0 in its low bits expires on the P-th tick after being loaded. With bit 30 set it reloads P and repeats. With bit 30 clear it stops and bit 31 reads back 0.
- R3: A timer expiry sets bit 30 of that timer's control register (address 0x14 + 8*i). Writing 1 to that bit clears it.
- R4: The stage advances by exactly one step per expiry of the timer selected by configuration bits 3:0 (address 0x00), and only while the watchdog is running. Expiries of other timers, and expiries before a start, leave the stage unchanged.
- R5: With configuration bit 4 set the stages run 0 → 1 → 2 → 3. With bit 4 clear they run 0 → 1 → 3.
- R6: irq_o is high while the stage is not 0 and configuration bit 12 is set. fiq_o is high while the stage is 2 or 3, bit 4 is set and bit 13 is set. Each output follows the stage in the same cycle.
- R7: On entry to stage 3, core_rst_o pulses for one cycle if configuration bit 14 is set, and pwr_rst_o pulses for one cycle if bit 15 is set. Further expiries hold stage 3 and produce no further pulse.
- R8: A command write (address 0x08) with bit 0 set starts the watchdog or restarts it. It sets the stage to 0 and reloads the selected timer's count.
- R9: A command with bit 1 set stops the watchdog and clears the stage, but only if the bus write just before it was the key 0x0000C45A to address 0x0C. Any command write uses up the key, and any other value written to 0x0C clears it. An unkeyed disable has no effect.
- R10: Status (address 0x04) reads bit 0 = running, bit 1 = pending (stage not 0) and bits 3:2 = stage. Configuration reads back only bits 15:12 and 4:0. Read data is valid on the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | 1 MHz count enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request level |
| fiq_o | output | 1 | Fast interrupt request level |
| core_rst_o | output | 1 | Core reset request pulse |
| pwr_rst_o | output | 1 | Power-controller reset request pulse |

## Verification
A tick sampled at clock edge E sets a timer's expiry register at E. The stage and all four outputs then change at E+1, and a timer's flag and period bits change at E. A command write changes the stage and the outputs at the edge where it is sampled. Read data appears one edge after rd_en. Each tick in the bench takes two cycles and the bench waits one idle cycle before it samples at the falling edge, so every result has settled before it is checked. Reset pulses are counted on every falling edge, so a pulse that shows up twice, or never, is seen.

// File: rtl/stagewd_pkg.sv
package stagewd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_FIQ  = 2'd2,
    ST_RST  = 2'd3
  } stage_e;

  localparam int A_CFG      = 'h00;
  localparam int A_STAT     = 'h04;
  localparam int A_CMD      = 'h08;
  localparam int A_KEY      = 'h0C;
  localparam int TMR_BASE   = 'h10;
  localparam int TMR_STRIDE = 8;

  localparam logic [31:0] KEY_VALUE = 32'h0000_C45A;
  localparam logic [15:0] CFG_MASK  = 16'hF01F;

  localparam int B_EN     = 31;
  localparam int B_PERIOD = 30;
  localparam int B_FLAG   = 30;
  localparam int B_THREE  = 4;
  localparam int B_IRQ    = 12;
  localparam int B_FIQ    = 13;
  localparam int B_CRST   = 14;
  localparam int B_PRST   = 15;
endpackage

// File: rtl/stagewd_timer.sv
module stagewd_timer #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        wr_ptv,
  input  logic        wr_ctl,
  input  logic [31:0] wdata,
  input  logic        reload,
  output logic [31:0] ptv_o,
  output logic        flag_o,
  output logic        expire_o
);
  import stagewd_pkg::*;

  logic [31:0]      ptv_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             exp_q;
  logic             hit;

  assign hit = !wr_ptv && !reload && tick && ptv_q[B_EN] && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptv_q  <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= hit;
      if (wr_ptv) begin
        ptv_q <= wdata;
        cnt_q <= wdata[CNT_W-1:0];
      end else if (reload) begin
        cnt_q <= ptv_q[CNT_W-1:0];
      end else if (tick && ptv_q[B_EN] && (cnt_q != '0)) begin
        if (hit) begin
          if (ptv_q[B_PERIOD]) begin
            cnt_q <= ptv_q[CNT_W-1:0];
          end else begin
            cnt_q        <= '0;
            ptv_q[B_EN]  <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      if (hit) begin
        flag_q <= 1'b1;
      end else if (wr_ctl && wdata[B_FLAG]) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign ptv_o    = ptv_q;
  assign flag_o   = flag_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/stagewd_ctrl.sv
module stagewd_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [15:0]       cfg_o,
  output logic              start_o,
  output logic              stop_o
);
  import stagewd_pkg::*;

  logic [15:0] cfg_q;
  logic        key_q;
  logic        cmd_wr;
  logic        key_wr;
  logic        cfg_wr;

  assign cmd_wr  = wr_en && (addr == ADDR_W'(A_CMD));
  assign key_wr  = wr_en && (addr == ADDR_W'(A_KEY));
  assign cfg_wr  = wr_en && (addr == ADDR_W'(A_CFG));
  assign stop_o  = cmd_wr && wdata[1] && key_q;
  assign start_o = cmd_wr && wdata[0] && !stop_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      key_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_q <= wdata[15:0] & CFG_MASK;
      end
      if (key_wr) begin
        key_q <= (wdata == KEY_VALUE);
      end else if (cmd_wr) begin
        key_q <= 1'b0;
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/stagewd_stage.sv
module stagewd_stage (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stop,
  input  logic       expire,
  input  logic       three_stage,
  input  logic       irq_en,
  input  logic       fiq_en,
  input  logic       crst_en,
  input  logic       prst_en,
  output logic [1:0] stage_o,
  output logic       running_o,
  output logic       irq_o,
  output logic       fiq_o,
  output logic       crst_o,
  output logic       prst_o
);
  import stagewd_pkg::*;

  stage_e stage_q, stage_d;
  logic   run_q, run_d;
  logic   enter_rst;
  logic   irq_q, fiq_q, crst_q, prst_q;

  always_comb begin
    stage_d = stage_q;
    run_d   = run_q;
    if (stop) begin
      run_d   = 1'b0;
      stage_d = ST_IDLE;
    end else if (start) begin
      run_d   = 1'b1;
      stage_d = ST_IDLE;
    end else if (expire && run_q) begin
      case (stage_q)
        ST_IDLE: stage_d = ST_IRQ;
        ST_IRQ:  stage_d = three_stage ? ST_FIQ : ST_RST;
        ST_FIQ:  stage_d = ST_RST;
        default: stage_d = ST_RST;
      endcase
    end
  end

  assign enter_rst = (stage_d == ST_RST) && (stage_q != ST_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
      crst_q  <= 1'b0;
      prst_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      run_q   <= run_d;
      irq_q   <= irq_en && (stage_d != ST_IDLE);
      fiq_q   <= fiq_en && three_stage && ((stage_d == ST_FIQ) || (stage_d == ST_RST));
      crst_q  <= crst_en && enter_rst;
      prst_q  <= prst_en && enter_rst;
    end
  end

  assign stage_o   = stage_q;
  assign running_o = run_q;
  assign irq_o     = irq_q;
  assign fiq_o     = fiq_q;
  assign crst_o    = crst_q;
  assign prst_o    = prst_q;
endmodule

// File: rtl/stagewd_top.sv
module stagewd_top #(
  parameter int ADDR_W  = 6,
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              core_rst_o,
  output logic              pwr_rst_o
);
  import stagewd_pkg::*;

  logic [15:0]        cfg_w;
  logic               start_p;
  logic               stop_p;
  logic [1:0]         stage_w;
  logic               running_w;
  logic               sel_exp;
  logic [NUM_TMR-1:0] exp_w;
  logic [NUM_TMR-1:0] flag_w;
  logic [NUM_TMR-1:0] wrp_w;
  logic [NUM_TMR-1:0] wrc_w;
  logic [NUM_TMR-1:0] rld_w;
  logic [31:0]        ptv_w [NUM_TMR];
  logic [31:0]        rd_d;
  logic [31:0]        rdata_q;

  stagewd_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cfg_o   (cfg_w),
    .start_o (start_p),
    .stop_o  (stop_p)
  );

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    localparam int PTV_A = TMR_BASE + TMR_STRIDE * gi;
    assign wrp_w[gi] = wr_en && (addr == ADDR_W'(PTV_A));
    assign wrc_w[gi] = wr_en && (addr == ADDR_W'(PTV_A + 4));
    assign rld_w[gi] = start_p && (cfg_w[3:0] == 4'(gi));

    stagewd_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick_us),
      .wr_ptv   (wrp_w[gi]),
      .wr_ctl   (wrc_w[gi]),
      .wdata    (wdata),
      .reload   (rld_w[gi]),
      .ptv_o    (ptv_w[gi]),
      .flag_o   (flag_w[gi]),
      .expire_o (exp_w[gi])
    );
  end

  always_comb begin
    sel_exp = 1'b0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (cfg_w[3:0] == 4'(i)) sel_exp = exp_w[i];
    end
  end

  stagewd_stage stage_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start_p),
    .stop        (stop_p),
    .expire      (sel_exp),
    .three_stage (cfg_w[B_THREE]),
    .irq_en      (cfg_w[B_IRQ]),
    .fiq_en      (cfg_w[B_FIQ]),
    .crst_en     (cfg_w[B_CRST]),
    .prst_en     (cfg_w[B_PRST]),
    .stage_o     (stage_w),
    .running_o   (running_w),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .crst_o      (core_rst_o),
    .prst_o      (pwr_rst_o)
  );

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(A_CFG))  rd_d = {16'b0, cfg_w};
    if (addr == ADDR_W'(A_STAT)) rd_d = {28'b0, stage_w, (stage_w != 2'd0), running_w};
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr == ADDR_W'(TMR_BASE + TMR_STRIDE * i))     rd_d = ptv_w[i];
      if (addr == ADDR_W'(TMR_BASE + TMR_STRIDE * i + 4)) rd_d = {1'b0, flag_w[i], 30'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/stagewd_chk.sv
module stagewd_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] stage,
  input logic       running,
  input logic       start_p,
  input logic       stop_p,
  input logic       sel_exp,
  input logic       irq_o,
  input logic       fiq_o,
  input logic       crst_o,
  input logic       prst_o
);
  // R7: reset requests last exactly one cycle
  p_core_pulse_r7: assert property (@(posedge clk) disable iff (rst) crst_o |=> !crst_o);
  p_pwr_pulse_r7:  assert property (@(posedge clk) disable iff (rst) prst_o |=> !prst_o);
  // R7: stage 3 is left only through a command
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(stage) == 2'd3 && stage != 2'd3) |-> ($past(start_p) || $past(stop_p)));
  // R6: interrupt outputs only in matching stages
  p_irq_stage_r6: assert property (@(posedge clk) disable iff (rst) irq_o |-> (stage != 2'd0));
  p_fiq_stage_r6: assert property (@(posedge clk) disable iff (rst) fiq_o |-> (stage[1] == 1'b1));
  // R4: a stage change without command needs a selected expiry while running
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (stage != $past(stage) && !$past(start_p) && !$past(stop_p)) |-> ($past(sel_exp) && $past(running)));
  // R9: running drops only on an accepted disable
  p_stop_r9: assert property (@(posedge clk) disable iff (rst) $fell(running) |-> $past(stop_p));
endmodule

bind stagewd_top stagewd_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .stage   (stage_w),
  .running (running_w),
  .start_p (start_p),
  .stop_p  (stop_p),
  .sel_exp (sel_exp),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .crst_o  (core_rst_o),
  .prst_o  (pwr_rst_o)
);

// File: tb/stagewd_top_tb.sv
module stagewd_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_us = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq_o, fiq_o, core_rst_o, pwr_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  int core_cnt = 0;
  int pwr_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stagewd_top dut_i (
    .clk(clk), .rst(rst), .tick_us(tick_us), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o),
    .core_rst_o(core_rst_o), .pwr_rst_o(pwr_rst_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (core_rst_o) core_cnt++;
      if (pwr_rst_o)  pwr_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_us = 1'b1;
      @(negedge clk); tick_us = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] stat_of(input int stage, input bit run);
    return {28'b0, 2'(stage), (stage != 0), run};
  endfunction

  function automatic int stage_after(input int n_exp, input bit three);
    if (n_exp == 0) return 0;
    if (three) return (n_exp >= 3) ? 3 : n_exp;
    return (n_exp == 1) ? 1 : 3;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd('h04, d); chk("R1 status", d, 0);
    rd('h00, d); chk("R1 cfg", d, 0);
    rd('h10, d); chk("R1 timer period", d, 0);
    rd('h14, d); chk("R1 timer flag", d, 0);
    chk("R1 outputs", {irq_o, fiq_o, core_rst_o, pwr_rst_o}, 0);

    // R2 / R3 periodic timer and flag
    wr('h10, 32'hC000_0003);
    ticks(2); rd('h14, d); chk("R2 not yet expired", d, 0);
    ticks(1); rd('h14, d); chk("R3 flag set", d, 32'h4000_0000);
    wr('h14, 32'h4000_0000); rd('h14, d); chk("R3 flag cleared", d, 0);
    ticks(3); rd('h14, d); chk("R2 periodic repeat", d, 32'h4000_0000);
    wr('h14, 32'h4000_0000);
    // R2 one-shot
    wr('h18, 32'h8000_0002);
    ticks(2); rd('h18, d); chk("R2 one-shot stops", d, 32'h0000_0002);
    rd('h1C, d); chk("R3 one-shot flag", d, 32'h4000_0000);

    // R10 cfg readback mask
    wr('h00, 32'hFFFF_FFFF); rd('h00, d); chk("R10 cfg mask", d, 32'h0000_F01F);

    // R4 not running: expiries ignored
    wr('h00, 32'h0000_F010);
    ticks(3); rd('h04, d); chk("R4 idle before start", d, 0);
    chk("R4 irq before start", irq_o, 0);

    // R5 three-stage sequence, R4 selection, R6, R7
    wr('h10, 32'hC000_0002);
    wr('h18, 32'hC000_0001);
    wr('h08, 32'h1); rd('h04, d); chk("R8 started", d, stat_of(0, 1));
    ticks(1); rd('h04, d); chk("R4 other timer ignored", d, stat_of(0, 1));
    ticks(1); rd('h04, d); chk("R5 stage1", d, stat_of(1, 1));
    chk("R6 irq stage1", {irq_o, fiq_o}, 2'b10);
    ticks(2); rd('h04, d); chk("R5 stage2", d, stat_of(2, 1));
    chk("R6 fiq stage2", {irq_o, fiq_o}, 2'b11);
    ticks(2); rd('h04, d); chk("R5 stage3", d, stat_of(3, 1));
    chk("R7 core pulse", core_cnt, 1);
    chk("R7 pwr pulse", pwr_cnt, 1);
    ticks(5); rd('h04, d); chk("R7 hold stage3", d, stat_of(3, 1));
    chk("R7 no repeat pulse", core_cnt, 1);

    // R8 restart clears and reloads
    wr('h08, 32'h1); rd('h04, d); chk("R8 restart clears", d, stat_of(0, 1));
    chk("R8 outputs clear", {irq_o, fiq_o}, 0);
    ticks(1); rd('h04, d); chk("R8 count reloaded", d, stat_of(0, 1));
    ticks(1); rd('h04, d); chk("R8 expiry after reload", d, stat_of(1, 1));

    // R9 keyed disable
    wr('h08, 32'h2); rd('h04, d); chk("R9 unkeyed disable ignored", d, stat_of(1, 1));
    wr('h0C, 32'h1234); wr('h08, 32'h2); rd('h04, d); chk("R9 wrong key", d, stat_of(1, 1));
    wr('h0C, 32'hC45A); wr('h08, 32'h0); wr('h08, 32'h2);
    rd('h04, d); chk("R9 key consumed", d, stat_of(1, 1));
    wr('h0C, 32'hC45A); wr('h08, 32'h2);
    rd('h04, d); chk("R9 keyed disable", d, 0);
    chk("R9 irq dropped", irq_o, 0);
    ticks(4); rd('h04, d); chk("R9 stays stopped", d, 0);

    // R5 two-stage mode
    wr('h00, 32'h0000_F000); wr('h08, 32'h1);
    ticks(2); rd('h04, d); chk("R5 two-stage first", d, stat_of(1, 1));
    ticks(2); rd('h04, d); chk("R5 two-stage reset", d, stat_of(3, 1));
    chk("R6 no fiq in two-stage", fiq_o, 0);
    chk("R7 core pulse two-stage", core_cnt, 2);

    // R6 / R7 enable gating
    wr('h00, 32'h0000_8010); wr('h08, 32'h1);
    ticks(2); rd('h04, d); chk("R6 stage1 gated", d, stat_of(1, 1));
    chk("R6 irq disabled", irq_o, 0);
    ticks(4); rd('h04, d); chk("R7 stage3 gated", d, stat_of(3, 1));
    chk("R7 only power pulse core", core_cnt, 2);
    chk("R7 only power pulse pwr", pwr_cnt, 3);
    chk("R6 fiq disabled", fiq_o, 0);

    // Random: R4 R5 R6 staging with random period, mode and ticks
    for (int it = 0; it < 16; it++) begin
      int p, n, st;
      bit three;
      p = 1 + int'($urandom % 4);
      three = 1'($urandom % 2);
      n = int'($urandom % (4 * p + 1));
      wr('h00, {16'b0, 4'b0011, 7'b0, three, 4'b0});
      wr('h10, 32'hC000_0000 | 32'(p));
      wr('h08, 32'h1);
      ticks(n);
      st = stage_after(n / p, three);
      rd('h04, d); chk("R4 random stage", d, stat_of(st, 1));
      chk("R6 random irq/fiq", {irq_o, fiq_o}, {st != 0, three && st >= 2});
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule